// File: doc/BRIEF.md
# ACPI System Power State Sequencer

This block is a synchronous state machine that follows the platform through its sleep states and drives the power-plane controls and the processor stop request. It has seven states:

- full on
- two processor stop-grant states, one where caches can be snooped and one where they cannot
- power-on suspend
- suspend to RAM
- soft off, which also serves as suspend to disk
- mechanical off

Software picks a sleep depth by pulsing a request together with a 3-bit target code. Once the platform is asleep, it is brought back by a pre-qualified resume pulse, by a power-button press, or (in the non-snoopable stop-grant state only) by any bus-master snoop request.

Auxiliary power has priority over everything else. When it is lost, the machine is in mechanical off after the next edge, whatever state it was in. When auxiliary power returns, a strap input picks between starting in full on and starting in soft off.

The power-button input is brought through a two-flop synchronizer and a falling-edge detector. A press of any length therefore counts as a single event.

Top module: `pwr_state_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, the state code is 6 (mechanical off), `main_en_n` is 1, `mem_pwr_en` is 0 and `stop_grant` is 0.
- R2: When `aux_ok` is 0 at a clock edge, the state code is 6 after that edge, from any state and regardless of the other inputs.
- R3: From mechanical off with `aux_ok` at 1, the next edge moves the machine to full on (code 0) if `boot_on` is 1, or to soft off (code 5) if `boot_on` is 0.
- R4: Only in full on, a `sleep_req` edge moves the machine according to `sleep_code`:
  - code 1 goes to the snoopable stop grant (code 1)
  - code 2 goes to the non-snoopable stop grant (code 2)
  - code 3 goes to power-on suspend (code 3)
  - code 4 goes to suspend to RAM (code 4)
  - codes 5 and 6 (suspend to disk, soft off) both go to soft off (code 5)
  - codes 0 and 7 leave the state unchanged
  - a request made in any other state is ignored.
- R5: In soft off and in mechanical off, `main_en_n` is 1 and `mem_pwr_en` is 0.
- R6: In suspend to RAM, `main_en_n` is 1 and `mem_pwr_en` is 1.
- R7: A 1-to-0 transition of `pwr_btn_n` is a press. It is acted on at the second clock edge after the edge that first samples the low level. A press moves soft off or suspend to RAM to full on exactly once, however long the button is held. A press in any other state is ignored.
- R8: A `wake` pulse at an edge returns any of these states to full on: either stop-grant state, power-on suspend, suspend to RAM, soft off.
- R9: In the non-snoopable stop-grant state, `snoop_req` at an edge returns the machine to full on. In the snoopable stop-grant state it has no effect.
- R10: `stop_grant` is 1 exactly in the states with codes 1 and 2. `main_en_n` is 0 exactly in the states with codes 0 to 3. `mem_pwr_en` is 1 in the states with codes 0 to 4.
- R11: The state code is one of 0 to 6 and never 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| aux_ok | input | 1 | Auxiliary planes powered |
| boot_on | input | 1 | Strap: 1 = go to full on when auxiliary power returns, 0 = go to soft off |
| pwr_btn_n | input | 1 | Power button, active low, asynchronous |
| sleep_req | input | 1 | Software sleep request strobe |
| sleep_code | input | 3 | Sleep target code |
| snoop_req | input | 1 | Bus-master snoop request |
| wake | input | 1 | Pre-qualified resume event pulse |
| main_en_n | output | 1 | Main supply enable, active low |
| mem_pwr_en | output | 1 | Memory power enable |
| stop_grant | output | 1 | Processor stop-grant request |
| state_code | output | 3 | Current state code |

## Verification
The assertions check the following on every clock:
- the auxiliary-loss override
- the strap choice on power return
- rejection of invalid sleep codes
- the snoop wake from the non-snoopable stop grant
- the supply pattern of each deep state
- that the stop-grant output appears only with the main planes on.

Some behaviours can only be shown by the bench's scenarios, which compare every cycle with a behavioural model:
- the two-edge latency of the button path
- that a long press causes exactly one transition
- that a press is ignored in power-on suspend
- that a request outside full on is ignored
- a full tour through every sleep depth and back.

// File: rtl/pwr_state_seq.sv
module pwr_state_seq #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aux_ok,
  input  logic              boot_on,
  input  logic              pwr_btn_n,
  input  logic              sleep_req,
  input  logic [CODE_W-1:0] sleep_code,
  input  logic              snoop_req,
  input  logic              wake,
  output logic              main_en_n,
  output logic              mem_pwr_en,
  output logic              stop_grant,
  output logic [CODE_W-1:0] state_code
);

  typedef enum logic [CODE_W-1:0] {
    ST_ON   = 3'd0,
    ST_SGS  = 3'd1,
    ST_SGN  = 3'd2,
    ST_POS  = 3'd3,
    ST_STR  = 3'd4,
    ST_SOFF = 3'd5,
    ST_MOFF = 3'd6
  } pstate_t;

  pstate_t st, st_nx;
  logic btn_m, btn_s, btn_d;
  logic press;
  logic main_up;

  assign press = btn_d & ~btn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_m <= 1'b1;
      btn_s <= 1'b1;
      btn_d <= 1'b1;
      st    <= ST_MOFF;
    end else begin
      btn_m <= pwr_btn_n;
      btn_s <= btn_m;
      btn_d <= btn_s;
      st    <= st_nx;
    end
  end

  always_comb begin
    st_nx = st;
    if (!aux_ok) begin
      st_nx = ST_MOFF;
    end else begin
      case (st)
        ST_MOFF: st_nx = boot_on ? ST_ON : ST_SOFF;
        ST_ON: begin
          if (sleep_req) begin
            case (sleep_code)
              3'd1:       st_nx = ST_SGS;
              3'd2:       st_nx = ST_SGN;
              3'd3:       st_nx = ST_POS;
              3'd4:       st_nx = ST_STR;
              3'd5, 3'd6: st_nx = ST_SOFF;
              default:    st_nx = ST_ON;
            endcase
          end
        end
        ST_SGS, ST_POS: if (wake) st_nx = ST_ON;
        ST_SGN:         if (wake || snoop_req) st_nx = ST_ON;
        ST_STR, ST_SOFF: if (wake || press) st_nx = ST_ON;
        default: st_nx = ST_MOFF;
      endcase
    end
  end

  assign main_up    = (st == ST_ON) || (st == ST_SGS) || (st == ST_SGN) || (st == ST_POS);
  assign main_en_n  = ~main_up;
  assign mem_pwr_en = main_up || (st == ST_STR);
  assign stop_grant = (st == ST_SGS) || (st == ST_SGN);
  assign state_code = st;

endmodule

module pwr_state_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       aux_ok,
  input logic       boot_on,
  input logic       sleep_req,
  input logic [2:0] sleep_code,
  input logic       snoop_req,
  input logic       main_en_n,
  input logic       mem_pwr_en,
  input logic       stop_grant,
  input logic [2:0] state_code
);

  assert_aux_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_ok |=> state_code == 3'd6);

  assert_power_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd6 && aux_ok) |=> state_code == ($past(boot_on) ? 3'd0 : 3'd5));

  assert_bad_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd0 && aux_ok && sleep_req && (sleep_code == 3'd0 || sleep_code == 3'd7))
      |=> state_code == 3'd0);

  assert_off_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd5 || state_code == 3'd6) |-> (main_en_n && !mem_pwr_en));

  assert_str_rails_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 3'd4 |-> (main_en_n && mem_pwr_en));

  assert_snoop_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd2 && aux_ok && snoop_req) |=> state_code == 3'd0);

  assert_stop_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_grant |-> (!main_en_n && (state_code == 3'd1 || state_code == 3'd2)));

  assert_legal_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state_code != 3'd7);

endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .aux_ok     (aux_ok),
  .boot_on    (boot_on),
  .sleep_req  (sleep_req),
  .sleep_code (sleep_code),
  .snoop_req  (snoop_req),
  .main_en_n  (main_en_n),
  .mem_pwr_en (mem_pwr_en),
  .stop_grant (stop_grant),
  .state_code (state_code)
);

// File: tb/pwr_state_seq_test.sv
`timescale 1ns/1ps
module pwr_state_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aux_ok = 1'b0, boot_on = 1'b0, pwr_btn_n = 1'b1;
  logic sleep_req = 1'b0, snoop_req = 1'b0, wake = 1'b0;
  logic [2:0] sleep_code = 3'd0;
  logic main_en_n, mem_pwr_en, stop_grant;
  logic [2:0] state_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_state_seq uut (
    .clk(clk), .rst_n(rst_n), .aux_ok(aux_ok), .boot_on(boot_on),
    .pwr_btn_n(pwr_btn_n), .sleep_req(sleep_req), .sleep_code(sleep_code),
    .snoop_req(snoop_req), .wake(wake), .main_en_n(main_en_n),
    .mem_pwr_en(mem_pwr_en), .stop_grant(stop_grant), .state_code(state_code)
  );

  // Behavioural reference: state as integer, button history as a queue.
  int m_st = 6;
  bit btn_q[$] = '{1, 1, 1};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 6;
      btn_q = '{1, 1, 1};
    end else begin
      bit pr;
      int nx;
      pr = (btn_q[1] == 0) && (btn_q[2] == 1);
      nx = m_st;
      if (!aux_ok) nx = 6;
      else if (m_st == 6) nx = boot_on ? 0 : 5;
      else if (m_st == 0) begin
        if (sleep_req && sleep_code >= 1 && sleep_code <= 4) nx = sleep_code;
        else if (sleep_req && (sleep_code == 5 || sleep_code == 6)) nx = 5;
      end
      else if (wake) nx = 0;
      else if (m_st == 2 && snoop_req) nx = 0;
      else if ((m_st == 4 || m_st == 5) && pr) nx = 0;
      m_st = nx;
      btn_q.push_front(pwr_btn_n);
      void'(btn_q.pop_back());
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit e_men_n, e_mem, e_sg;
      string tag;
      e_men_n = !(m_st <= 3);
      e_mem   = (m_st <= 4);
      e_sg    = (m_st == 1 || m_st == 2);
      tag = (m_st == 4) ? "R6" : (m_st >= 5) ? "R5" : "R10";
      checks++;
      if (state_code != m_st[2:0]) begin
        errors++;
        $display("FAIL R11 state_code actual %0d expected %0d", state_code, m_st);
      end
      if (main_en_n != e_men_n || mem_pwr_en != e_mem) begin
        errors++;
        $display("FAIL %s rails actual %b%b expected %b%b", tag, main_en_n, mem_pwr_en, e_men_n, e_mem);
      end
      if (stop_grant != e_sg) begin
        errors++;
        $display("FAIL R10 stop_grant actual %b expected %b", stop_grant, e_sg);
      end
    end
  end

  task automatic chk(input int exp, input string req);
    checks++;
    if (state_code != exp[2:0]) begin
      errors++;
      $display("FAIL %s state actual %0d expected %0d", req, state_code, exp);
    end
  endtask

  task automatic req_sleep(input int code);
    @(negedge clk); sleep_req = 1'b1; sleep_code = code[2:0];
    @(negedge clk); sleep_req = 1'b0; sleep_code = 3'd0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic pulse_snoop();
    @(negedge clk); snoop_req = 1'b1;
    @(negedge clk); snoop_req = 1'b0;
  endtask

  task automatic press_btn(input int hold);
    @(negedge clk); pwr_btn_n = 1'b0;
    repeat (hold) @(negedge clk);
    pwr_btn_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(6, "R1");
    checks++;
    if (!(main_en_n && !mem_pwr_en && !stop_grant)) begin
      errors++;
      $display("FAIL R1 outputs actual %b%b%b expected 100", main_en_n, mem_pwr_en, stop_grant);
    end
    rst_n = 1'b1;
    @(negedge clk); chk(6, "R1");

    // R3: power returns with strap low
    aux_ok = 1'b1; boot_on = 1'b0;
    @(negedge clk); chk(5, "R3");

    // R7: press latency and single transition
    @(negedge clk); pwr_btn_n = 1'b0;
    @(negedge clk); chk(5, "R7");
    @(negedge clk); chk(5, "R7");
    @(negedge clk); chk(0, "R7");
    repeat (6) @(negedge clk);
    pwr_btn_n = 1'b1;
    repeat (3) @(negedge clk); chk(0, "R7");

    // R4: invalid codes
    req_sleep(0); chk(0, "R4");
    req_sleep(7); chk(0, "R4");

    // Snoopable stop grant
    req_sleep(1); chk(1, "R4");
    pulse_snoop(); chk(1, "R9");
    req_sleep(3); chk(1, "R4");
    pulse_wake(); chk(0, "R8");

    // Non-snoopable stop grant
    req_sleep(2); chk(2, "R4");
    pulse_snoop(); chk(0, "R9");
    req_sleep(2); pulse_wake(); chk(0, "R8");

    // Power-on suspend ignores the button
    req_sleep(3); chk(3, "R4");
    press_btn(4); chk(3, "R7");
    pulse_wake(); chk(0, "R8");

    // Suspend to RAM
    req_sleep(4); chk(4, "R6");
    pulse_wake(); chk(0, "R8");
    req_sleep(4); chk(4, "R6");
    press_btn(2); chk(0, "R7");

    // Suspend to disk and soft off share a state
    req_sleep(5); chk(5, "R5");
    press_btn(1); chk(0, "R7");
    req_sleep(6); chk(5, "R5");
    pulse_wake(); chk(0, "R8");
    req_sleep(6);

    // Auxiliary loss and strap high
    @(negedge clk); aux_ok = 1'b0;
    @(negedge clk); chk(6, "R2");
    boot_on = 1'b1; wake = 1'b1;
    @(negedge clk); chk(6, "R2");
    wake = 1'b0; aux_ok = 1'b1;
    @(negedge clk); chk(0, "R3");
    req_sleep(2); chk(2, "R4");
    @(negedge clk); aux_ok = 1'b0; snoop_req = 1'b1;
    @(negedge clk); chk(6, "R2");
    snoop_req = 1'b0; aux_ok = 1'b1;
    @(negedge clk); chk(0, "R3");
    req_sleep(3);
    @(negedge clk); aux_ok = 1'b0;
    @(negedge clk); chk(6, "R2");
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule